// File: doc/BRIEF.md
# External Trigger Timestamp Capture Unit

This block takes a snapshot of a free-running 64-bit time value each time a selected edge arrives on one of two external trigger pins. Each pin passes through its own two-stage synchroniser and edge detector. The snapshot is pushed into a 16-entry queue that belongs to that channel. Software drains the queue over a simple register bus. It reads a low word and then a high word for each timestamp, and the read of the high word removes the entry. It can keep reading pairs until the channel's valid flag drops.

Each channel raises three sticky event flags. One marks that a trigger was seen, one that the queue fill level has reached a programmable threshold, and one that a capture was dropped because the queue was full. A mask register selects which flags drive the single interrupt line. Software clears a flag by writing 1 to it. The time counter is not part of the block: it arrives on an input port.

Register bus timing: a read strobe with an address returns its word on `regRdData` at the next rising clock edge. A write strobe takes effect at the rising edge on which it is sampled. Register offsets:
- `0x80` control
- `0x84` events
- `0x88` event mask
- `0x94` status
- `0xAC` threshold
- `0xE0 + 8*i` timestamp low word for channel i
- `0xE4 + 8*i` timestamp high word for channel i

Top module: `trig_stamp_unit`

## Requirements
- R1: Each of the two trigger inputs is sampled by a two-flop synchroniser. A level change that is set up before rising clock edge N is captured into the queue at edge N+2. The stored value is the `timeNow` input as seen at that edge.
- R2: Control register bit 8+i selects the capture edge for channel i. A value of 0 captures on rising edges and 1 captures on falling edges. The opposite edge captures nothing.
- R3: Each channel keeps up to 16 timestamps and returns them in first-in first-out order.
- R4: A read at `0xE0+8*i` returns bits 31:0 of channel i's oldest entry. A read at `0xE4+8*i` returns bits 63:32 of that entry and removes it. Only the high-word read changes the queue.
- R5: Reading either timestamp word of an empty channel returns zero and leaves every queue and status unchanged.
- R6: Status register bit 24+i reads 1 exactly while channel i holds at least one unread entry.
- R7: A capture that arrives while the queue is full (16 entries, no removal in the same cycle) is discarded. It sets event bit 28+i, and the 16 stored entries stay intact and in order.
- R8: The threshold register holds the level in bits 4:0 and resets to 7. A capture that brings channel i's fill level exactly to a nonzero threshold sets event bit 20+i.
- R9: Every detected trigger edge on channel i sets event bit 24+i, including one that is dropped on overflow.
- R10: Event bits are sticky. Writing 1 to a bit of the event register clears it. Writing 0 leaves it unchanged. A new event in the same cycle as its clear keeps the bit set.
- R11: The event mask register at `0x88` uses the event bit positions. The `irq` output is high exactly when some event bit and its mask bit are both 1.
- R12: After reset the control, event and mask registers and the status register read 0, the threshold reads 7, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 2 | Asynchronous external trigger pins, one per channel |
| timeNow | input | 64 | Current time counter value |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid the cycle after the read strobe |
| irq | output | 1 | Interrupt, OR of masked events |

## Verification
The assertions assume that reset is held over at least one rising edge before any stimulus. They also assume that `timeNow` and the register strobes change only away from the rising edge, and that each trigger level is held long enough for the synchroniser to see it. Under these assumptions, removal from an empty queue, growth past 16 entries and a push onto a full queue without a matching removal cannot occur. The stimulus keeps to these assumptions. It drives every input on the falling clock edge and holds each trigger level for several cycles. It advances `timeNow` by a fixed step on each falling edge, so the expected stamp is the value visible at the capture edge that R1 names.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int NUM_CH = 2;
  localparam int TS_W = 64;

  localparam logic [7:0] ADDR_CTRL    = 8'h80;
  localparam logic [7:0] ADDR_EVT     = 8'h84;
  localparam logic [7:0] ADDR_MASK    = 8'h88;
  localparam logic [7:0] ADDR_STAT    = 8'h94;
  localparam logic [7:0] ADDR_THR     = 8'hAC;
  localparam logic [7:0] ADDR_TS_BASE = 8'hE0;

  localparam int POL_BIT = 8;
  localparam int THR_EVT_BIT = 20;
  localparam int CAP_EVT_BIT = 24;
  localparam int OVF_EVT_BIT = 28;
  localparam int VLD_BIT = 24;

  typedef struct packed {
    logic [NUM_CH-1:0] push;
    logic [NUM_CH-1:0] pop;
  } tsuStrobe_t;

  function automatic logic [31:0] evtBitsAll();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      m[THR_EVT_BIT+i] = 1'b1;
      m[CAP_EVT_BIT+i] = 1'b1;
      m[OVF_EVT_BIT+i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/tsu_fifo.sv
module tsu_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      if (push && !pop)      count <= count + CNT_W'(1);
      else if (pop && !push) count <= count - CNT_W'(1);
    end
  end

  // R3: fill level never exceeds the depth
  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R7: a push into a full queue only happens together with a removal
  a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (push && full) |-> pop);
endmodule

// File: rtl/tsu_datapath.sv
module tsu_datapath import tsu_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  tsuStrobe_t                        strobe,
  input  logic [TS_W-1:0]                   timeNow,
  output logic [NUM_CH-1:0][TS_W-1:0]       headTs,
  output logic [NUM_CH-1:0][CNT_W-1:0]      level,
  output logic [NUM_CH-1:0]                 fifoFull,
  output logic [NUM_CH-1:0]                 fifoEmpty
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tsu_fifo #(.DEPTH(DEPTH), .WIDTH(TS_W)) uFifo (
      .clk    (clk),
      .rstN   (rstN),
      .push   (strobe.push[i]),
      .pop    (strobe.pop[i]),
      .wrData (timeNow),
      .head   (headTs[i]),
      .count  (level[i]),
      .full   (fifoFull[i]),
      .empty  (fifoEmpty[i])
    );
  end
endmodule

// File: rtl/tsu_ctrl.sv
module tsu_ctrl import tsu_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int THR_W = 5,
  parameter int ADDR_W = 8,
  parameter int THR_RST = 7,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             trigIn,
  input  logic                          regWrEn,
  input  logic                          regRdEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [31:0]                   regWrData,
  output logic [31:0]                   regRdData,
  output logic                          irq,
  output tsuStrobe_t                    strobe,
  input  logic [NUM_CH-1:0][TS_W-1:0]   headTs,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  level,
  input  logic [NUM_CH-1:0]             fifoFull,
  input  logic [NUM_CH-1:0]             fifoEmpty
);
  localparam logic [31:0] EVT_ALL = evtBitsAll();

  logic [NUM_CH-1:0] syncA, syncB, syncPrev;
  logic [NUM_CH-1:0] capEdge, ovfSet, thrSet;
  logic [NUM_CH-1:0] polSel;
  logic [NUM_CH-1:0] thrEvt, capEvt, ovfEvt;
  logic [NUM_CH-1:0] rdLo, rdHi;
  logic [31:0]       maskR, evtWord, statWord;
  logic [THR_W-1:0]  thrLevel;
  logic              evtWr;

  // Two-flop synchroniser plus one stage of history for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncPrev <= '0;
    end else begin
      syncA <= trigIn;
      syncB <= syncA;
      syncPrev <= syncB;
    end
  end

  assign evtWr = regWrEn && (regAddr == ADDR_W'(ADDR_EVT));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CNT_W:0] levelNext;

    assign capEdge[i] = polSel[i] ? (syncPrev[i] & ~syncB[i])
                                  : (syncB[i] & ~syncPrev[i]);
    assign rdLo[i] = regAddr == ADDR_W'(ADDR_TS_BASE + 8 * i);
    assign rdHi[i] = regAddr == ADDR_W'(ADDR_TS_BASE + 8 * i + 4);

    assign strobe.pop[i]  = regRdEn && rdHi[i] && !fifoEmpty[i];
    assign strobe.push[i] = capEdge[i] && (!fifoFull[i] || strobe.pop[i]);
    assign ovfSet[i]      = capEdge[i] && fifoFull[i] && !strobe.pop[i];

    assign levelNext = {1'b0, level[i]} + (CNT_W+1)'(strobe.push[i])
                     - (CNT_W+1)'(strobe.pop[i]);
    assign thrSet[i] = strobe.push[i] && (thrLevel != '0)
                     && (levelNext == (CNT_W+1)'(thrLevel));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        thrEvt[i] <= 1'b0;
        capEvt[i] <= 1'b0;
        ovfEvt[i] <= 1'b0;
      end else begin
        thrEvt[i] <= thrSet[i]  | (thrEvt[i] & ~(evtWr & regWrData[THR_EVT_BIT+i]));
        capEvt[i] <= capEdge[i] | (capEvt[i] & ~(evtWr & regWrData[CAP_EVT_BIT+i]));
        ovfEvt[i] <= ovfSet[i]  | (ovfEvt[i] & ~(evtWr & regWrData[OVF_EVT_BIT+i]));
      end
    end

    // R5: an empty queue is never popped
    a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
      fifoEmpty[i] |-> !strobe.pop[i]);

    // R10: a trigger flag stays set until a 1 is written to it
    a_r10_event_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (capEvt[i] && !(evtWr && regWrData[CAP_EVT_BIT+i])) |=> capEvt[i]);

    // R7: a dropped capture leaves the queue full
    a_r7_drop_keeps_full: assert property (@(posedge clk) disable iff (!rstN)
      ovfSet[i] |=> fifoFull[i]);

    // R2: one level change yields one detected edge
    a_r2_single_edge: assert property (@(posedge clk) disable iff (!rstN)
      capEdge[i] |=> !capEdge[i]);
  end

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      polSel   <= '0;
      maskR    <= '0;
      thrLevel <= THR_W'(THR_RST);
    end else if (regWrEn) begin
      if (regAddr == ADDR_W'(ADDR_CTRL)) polSel <= regWrData[POL_BIT +: NUM_CH];
      if (regAddr == ADDR_W'(ADDR_MASK)) maskR <= regWrData & EVT_ALL;
      if (regAddr == ADDR_W'(ADDR_THR))  thrLevel <= regWrData[THR_W-1:0];
    end
  end

  always_comb begin
    evtWord = '0;
    statWord = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      evtWord[THR_EVT_BIT+i] = thrEvt[i];
      evtWord[CAP_EVT_BIT+i] = capEvt[i];
      evtWord[OVF_EVT_BIT+i] = ovfEvt[i];
      statWord[VLD_BIT+i] = !fifoEmpty[i];
    end
  end

  assign irq = |(evtWord & maskR);

  // Registered read data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData <= '0;
    end else if (regRdEn) begin
      regRdData <= '0;
      if (regAddr == ADDR_W'(ADDR_CTRL)) regRdData <= 32'(polSel) << POL_BIT;
      if (regAddr == ADDR_W'(ADDR_EVT))  regRdData <= evtWord;
      if (regAddr == ADDR_W'(ADDR_MASK)) regRdData <= maskR;
      if (regAddr == ADDR_W'(ADDR_STAT)) regRdData <= statWord;
      if (regAddr == ADDR_W'(ADDR_THR))  regRdData <= 32'(thrLevel);
      for (int i = 0; i < NUM_CH; i++) begin
        if (rdLo[i] && !fifoEmpty[i]) regRdData <= headTs[i][31:0];
        if (rdHi[i] && !fifoEmpty[i]) regRdData <= headTs[i][63:32];
      end
    end
  end
endmodule

// File: rtl/trig_stamp_unit.sv
module trig_stamp_unit import tsu_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int THR_W = 5,
  parameter int ADDR_W = 8,
  parameter int THR_RST = 7,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        trigIn,
  input  logic [63:0]       timeNow,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irq
);
  tsuStrobe_t                    strobe;
  logic [NUM_CH-1:0][TS_W-1:0]   headTs;
  logic [NUM_CH-1:0][CNT_W-1:0]  level;
  logic [NUM_CH-1:0]             fifoFull, fifoEmpty;

  tsu_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W), .ADDR_W(ADDR_W), .THR_RST(THR_RST)) uCtrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .strobe(strobe), .headTs(headTs), .level(level),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty)
  );

  tsu_datapath #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .timeNow(timeNow),
    .headTs(headTs), .level(level), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty)
  );
endmodule

// File: tb/trig_stamp_unit_test.sv
`timescale 1ns/1ps
module trig_stamp_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  trigIn = '0;
  logic [63:0] timeNow = 64'h0000_0123_4567_0000;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;

  int checks = 0;
  int fails = 0;

  trig_stamp_unit uut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .timeNow(timeNow),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      timeNow = timeNow + 64'd13;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic readTs(input int ch, output logic [63:0] ts);
    logic [31:0] lo, hi;
    regRead(8'hE0 + 8'(8 * ch), lo);
    regRead(8'hE4 + 8'(8 * ch), hi);
    ts = {hi, lo};
  endtask

  // Flip a trigger pin; stamp is the time seen at the capture edge (R1)
  task automatic toggle(input int ch, output logic [63:0] stamp);
    @(negedge clk);
    trigIn[ch] = ~trigIn[ch];
    repeat (3) @(posedge clk);
    stamp = timeNow;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input int ch, output logic [63:0] stamp);
    logic [63:0] unused;
    toggle(ch, stamp);
    toggle(ch, unused);
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRead(8'h80, d); chk("R12 ctrl reset", 64'(d), 64'h0);
    regRead(8'h84, d); chk("R12 event reset", 64'(d), 64'h0);
    regRead(8'h88, d); chk("R12 mask reset", 64'(d), 64'h0);
    regRead(8'h94, d); chk("R12 status reset", 64'(d), 64'h0);
    regRead(8'hAC, d); chk("R12 threshold reset", 64'(d), 64'd7);
    chk("R12 irq reset", 64'(irq), 64'h0);
  endtask

  task automatic testRiseCapture();
    logic [63:0] s, got;
    logic [31:0] d;
    pulse(0, s);
    regRead(8'h94, d); chk("R6 valid set ch0", 64'(d[24]), 64'h1);
    regRead(8'h84, d); chk("R9 trigger event ch0", 64'(d[24]), 64'h1);
    readTs(0, got);    chk("R1 R4 stamp ch0", got, s);
    regRead(8'h94, d); chk("R6 valid clear after pop", 64'(d[24]), 64'h0);
  endtask

  task automatic testOrder();
    logic [63:0] s [3];
    logic [63:0] got;
    for (int k = 0; k < 3; k++) pulse(0, s[k]);
    for (int k = 0; k < 3; k++) begin
      readTs(0, got);
      chk("R3 fifo order", got, s[k]);
    end
  endtask

  task automatic testEmpty();
    logic [63:0] s, got;
    logic [31:0] d;
    pulse(1, s);
    readTs(0, got);    chk("R5 empty read zero", got, 64'h0);
    regRead(8'h94, d); chk("R5 status unchanged", 64'(d[25:24]), 64'h2);
    readTs(1, got);    chk("R5 other channel intact", got, s);
  endtask

  task automatic testPolarity();
    logic [63:0] s, got;
    logic [31:0] d;
    regWrite(8'h80, 32'h0000_0200);
    toggle(1, s);
    regRead(8'h94, d); chk("R2 rising ignored on falling mode", 64'(d[25]), 64'h0);
    toggle(1, s);
    regRead(8'h94, d); chk("R2 falling captured", 64'(d[25]), 64'h1);
    readTs(1, got);    chk("R2 falling stamp", got, s);
    regWrite(8'h80, 32'h0);
  endtask

  task automatic testEvents();
    logic [63:0] s, got;
    logic [31:0] d;
    regWrite(8'h84, 32'hFFFF_FFFF);
    regRead(8'h84, d); chk("R10 clear all", 64'(d), 64'h0);
    pulse(1, s);
    chk("R11 masked off", 64'(irq), 64'h0);
    regWrite(8'h88, 32'h0200_0000);
    @(negedge clk); chk("R11 masked on", 64'(irq), 64'h1);
    regWrite(8'h84, 32'h0100_0000);
    regRead(8'h84, d); chk("R10 other bit kept", 64'(d[25]), 64'h1);
    chk("R11 irq still high", 64'(irq), 64'h1);
    regWrite(8'h84, 32'h0200_0000);
    regRead(8'h84, d); chk("R10 w1c clears", 64'(d[25]), 64'h0);
    chk("R11 irq low after clear", 64'(irq), 64'h0);
    readTs(1, got);
    regWrite(8'h88, 32'h0);
  endtask

  task automatic testThreshold();
    logic [63:0] s, got;
    logic [31:0] d;
    regWrite(8'hAC, 32'd3);
    regWrite(8'h84, 32'hFFFF_FFFF);
    pulse(0, s); pulse(0, s);
    regRead(8'h84, d); chk("R8 below threshold", 64'(d[20]), 64'h0);
    pulse(0, s);
    regRead(8'h84, d); chk("R8 threshold reached", 64'(d[20]), 64'h1);
    for (int k = 0; k < 3; k++) readTs(0, got);
    regWrite(8'hAC, 32'd7);
  endtask

  task automatic testOverflow();
    logic [63:0] s [16];
    logic [63:0] extra, got;
    logic [31:0] d;
    regWrite(8'h84, 32'hFFFF_FFFF);
    for (int k = 0; k < 16; k++) pulse(0, s[k]);
    regRead(8'h84, d); chk("R7 no overflow at 16", 64'(d[28]), 64'h0);
    regWrite(8'h84, 32'h0100_0000);
    pulse(0, extra);
    regRead(8'h84, d);
    chk("R7 overflow flagged", 64'(d[28]), 64'h1);
    chk("R9 trigger flagged on drop", 64'(d[24]), 64'h1);
    for (int k = 0; k < 16; k++) begin
      readTs(0, got);
      chk("R7 R3 entries kept", got, s[k]);
    end
    regRead(8'h94, d); chk("R7 drained", 64'(d[24]), 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testRiseCapture();
    testOrder();
    testEmpty();
    testPolarity();
    testEvents();
    testThreshold();
    testOverflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule